// File: doc/BRIEF.md
# Card clock divider with staged update

This block derives a card clock from a reference clock. The clock has a programmable even division ratio, and the card clock can be switched off. Software writes the wanted ratio, the enable and a source selector into staged registers. None of these writes touches the running clock. The new values take effect only when software writes a command word that carries both a start flag and an update-only flag.

The start flag reads back as set while the update is pending. The block clears the flag once the staged values have been copied into the active settings. An optional wait flag in the command holds the update back for as long as an external data-path busy input is high. If software issues another start while one is still pending, a sticky lock error is raised and the second command is dropped.

The generator picks up new active settings only while its output is low. A high pulse is therefore never cut short. When the enable is clear, the card clock stays low. A ratio of zero passes the reference clock straight through, gated by a latch that changes only while the reference clock is low.

Top module: `ckdiv_top`

## Requirements
- R1: After reset the card clock is low, busy is 0, the lock error is 0, the start bit (command register, offset 3, bit 31) reads 0, and the divider register (offset 0) reads the reset ratio 1.
- R2: Writes to the divider (offset 0, bits 7:0), enable (offset 1, bit 0) and source (offset 2) registers leave the card clock unchanged until an update command is accepted.
- R3: Writing the command register with bit 31 (start) and bit 21 (update-only) set makes busy and the start bit read 1 in the cycle after the write. When no wait is requested, both return to 0 one cycle later.
- R4: With the enable at 1 and a ratio N between 1 and 255, the card clock is high for N reference cycles and then low for N cycles, so its period is 2N.
- R5: After an update that applies enable 0, the card clock is held low.
- R6: After an update that applies ratio 0 with the enable at 1, the card clock follows the reference clock.
- R7: When command bit 13 (wait) is set, the update stays pending while the data-busy input is high, and it completes one cycle after that input falls. Status register offset 4, bit 9, shows the data-busy input.
- R8: A start written while an update is pending sets the lock error, which is raw status offset 5, bit 12. The dropped command leaves the pending command bits unchanged. Writing 1 to that bit clears the error.
- R9: A command with start set but without update-only clears its start bit in the same way. It does not apply the staged settings.
- R10: A new ratio applied while the card clock is high does not shorten that high pulse. The next pulses use the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| data_busy | input | 1 | Data path busy from the transfer logic |
| cclk | output | 1 | Card clock |
| busy | output | 1 | Update pending |
| lock_err | output | 1 | Sticky lock error |
| src_sel | output | 2 | Applied source selector |

## Verification
A write lands on the clock edge that samples it. The start bit and busy are therefore checked at the falling edge right after the write task. Acceptance is checked at the next falling edge, and the new clock appears one edge after acceptance. Clock ratios are measured from sample times taken 1 ns after each rising edge: the distance between a rise and the following fall gives the high length, and the distance from that fall to the next rise gives the low length, both in reference periods. Passthrough is checked by sampling just after both edges of the reference clock. Holds and ignored commands are checked by watching the card clock for several complete ratio periods.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
   localparam int REG_W   = 32;
   localparam int ADDR_W  = 3;
   // register offsets
   localparam logic [ADDR_W-1:0] A_DIV  = 3'd0;
   localparam logic [ADDR_W-1:0] A_ENA  = 3'd1;
   localparam logic [ADDR_W-1:0] A_SRC  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CMD  = 3'd3;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
   localparam logic [ADDR_W-1:0] A_RAW  = 3'd5;
   // field positions decoded by software
   localparam int B_START = 31;
   localparam int B_UPD   = 21;
   localparam int B_WAIT  = 13;
   localparam int B_BUSY  = 9;
   localparam int B_LOCK  = 12;
endpackage

// File: rtl/ckdiv_regs.sv
module ckdiv_regs
   import ckdiv_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int SRC_W   = 2,
   parameter int RST_DIV = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              data_busy,
   output logic [REG_W-1:0]  rdata,
   output logic [DIV_W-1:0]  act_div,
   output logic              act_ena,
   output logic [SRC_W-1:0]  act_src,
   output logic              pend,
   output logic              pend_wait,
   output logic              lock_err
);
   logic [DIV_W-1:0] stg_div;
   logic             stg_ena;
   logic [SRC_W-1:0] stg_src;
   logic             pend_upd;
   logic             cmd_wr, accept;

   assign cmd_wr = wr_en && (addr == A_CMD) && wdata[B_START];
   assign accept = pend && !(pend_wait && data_busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_div   <= DIV_W'(RST_DIV);
         stg_ena   <= 1'b0;
         stg_src   <= '0;
         act_div   <= DIV_W'(RST_DIV);
         act_ena   <= 1'b0;
         act_src   <= '0;
         pend      <= 1'b0;
         pend_wait <= 1'b0;
         pend_upd  <= 1'b0;
         lock_err  <= 1'b0;
      end else begin
         if (wr_en && addr == A_DIV) stg_div <= wdata[DIV_W-1:0];
         if (wr_en && addr == A_ENA) stg_ena <= wdata[0];
         if (wr_en && addr == A_SRC) stg_src <= wdata[SRC_W-1:0];
         if (wr_en && addr == A_RAW && wdata[B_LOCK]) lock_err <= 1'b0;
         if (pend) begin
            if (cmd_wr) lock_err <= 1'b1;
            if (accept) begin
               pend <= 1'b0;
               if (pend_upd) begin
                  act_div <= stg_div;
                  act_ena <= stg_ena;
                  act_src <= stg_src;
               end
            end
         end else if (cmd_wr) begin
            pend      <= 1'b1;
            pend_wait <= wdata[B_WAIT];
            pend_upd  <= wdata[B_UPD];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_DIV:  rdata[DIV_W-1:0] = stg_div;
         A_ENA:  rdata[0] = stg_ena;
         A_SRC:  rdata[SRC_W-1:0] = stg_src;
         A_CMD: begin
            rdata[B_START] = pend;
            rdata[B_UPD]   = pend_upd;
            rdata[B_WAIT]  = pend_wait;
         end
         A_STAT: rdata[B_BUSY] = data_busy;
         A_RAW:  rdata[B_LOCK] = lock_err;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/ckdiv_gen.sv
module ckdiv_gen #(
   parameter int DIV_W     = 8,
   parameter int RST_DIV   = 1,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] act_div,
   input  logic             act_ena,
   output logic             cclk
);
   logic [DIV_W-1:0] run_div, cnt;
   logic             run_ena, div_q, gate_q, at_end, idle;

   assign at_end = (cnt == run_div - DIV_W'(1));
   assign idle   = !run_ena || (run_div == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= 1'b0;
         cnt     <= '0;
         run_div <= DIV_W'(RST_DIV);
         run_ena <= 1'b0;
      end else if (div_q) begin
         if (at_end) begin
            div_q <= 1'b0;
            cnt   <= '0;
         end else begin
            cnt <= cnt + DIV_W'(1);
         end
      end else if (idle || at_end) begin
         run_div <= act_div;
         run_ena <= act_ena;
         cnt     <= '0;
         div_q   <= act_ena && (act_div != '0);
      end else begin
         cnt <= cnt + DIV_W'(1);
      end
   end

   generate
      if (BYPASS_EN) begin : g_pass
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) gate_q <= 1'b0;
            else        gate_q <= run_ena && (run_div == '0);
         end
      end else begin : g_nopass
         assign gate_q = 1'b0;
      end
   endgenerate

   assign cclk = div_q | (clk & gate_q);
endmodule

// File: rtl/ckdiv_top.sv
module ckdiv_top
   import ckdiv_pkg::*;
#(
   parameter int DIV_W     = 8,
   parameter int SRC_W     = 2,
   parameter int RST_DIV   = 1,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   input  logic              data_busy,
   output logic              cclk,
   output logic              busy,
   output logic              lock_err,
   output logic [SRC_W-1:0]  src_sel
);
   generate
      if (DIV_W < 1 || DIV_W > 12) begin : g_bad_div
         $error("ckdiv_top: DIV_W out of range");
      end
      if (SRC_W < 1 || SRC_W > 4) begin : g_bad_src
         $error("ckdiv_top: SRC_W out of range");
      end
   endgenerate

   logic [DIV_W-1:0] act_div;
   logic             act_ena, pend_wait;

   ckdiv_regs #(.DIV_W(DIV_W), .SRC_W(SRC_W), .RST_DIV(RST_DIV)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .data_busy(data_busy), .rdata(rdata), .act_div(act_div),
      .act_ena(act_ena), .act_src(src_sel), .pend(busy),
      .pend_wait(pend_wait), .lock_err(lock_err)
   );

   ckdiv_gen #(.DIV_W(DIV_W), .RST_DIV(RST_DIV), .BYPASS_EN(BYPASS_EN)) u_gen (
      .clk(clk), .rst_n(rst_n), .act_div(act_div), .act_ena(act_ena),
      .cclk(cclk)
   );
endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk
   import ckdiv_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [REG_W-1:0]  wdata,
   input logic              data_busy,
   input logic              busy,
   input logic              pend_wait,
   input logic              lock_err,
   input logic [DIV_W-1:0]  act_div,
   input logic              act_ena
);
   p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ($stable(act_div) && $stable(act_ena)));

   p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !data_busy) |=> !busy);

   p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pend_wait && data_busy) |=> busy);

   p_lock_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && addr == A_CMD && wdata[B_START]) |=> lock_err);
endmodule

bind ckdiv_top ckdiv_chk #(.DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .data_busy(data_busy), .busy(busy), .pend_wait(pend_wait),
   .lock_err(lock_err), .act_div(act_div), .act_ena(act_ena)
);

// File: tb/sim_ckdiv_top.sv
`timescale 1ns/1ps
module sim_ckdiv_top;
   localparam int PERIOD = 10;
   localparam int NV = 7;
   // {enable, ratio}
   localparam logic [8:0] VEC [NV] = '{9'h101, 9'h102, 9'h103, 9'h105,
                                       9'h004, 9'h100, 9'h107};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        data_busy = 1'b0;
   logic        cclk, busy, lock_err;
   logic [1:0]  src_sel;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   ckdiv_top u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .data_busy(data_busy), .cclk(cclk),
      .busy(busy), .lock_err(lock_err), .src_sel(src_sel));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic update();
      wr(3'd3, 32'h8020_0000);
      repeat (2) @(negedge clk);
   endtask

   // samples 1 ns after rising edges, returns high and low lengths
   task automatic measure(output int hi, output int lo);
      time t1, t2, t3;
      int guard = 0;
      @(posedge clk); #1;
      while (cclk && guard < 700) begin @(posedge clk); #1; guard++; end
      while (!cclk && guard < 700) begin @(posedge clk); #1; guard++; end
      t1 = $time;
      while (cclk && guard < 700) begin @(posedge clk); #1; guard++; end
      t2 = $time;
      while (!cclk && guard < 700) begin @(posedge clk); #1; guard++; end
      t3 = $time;
      hi = int'((t2 - t1) / PERIOD);
      lo = int'((t3 - t2) / PERIOD);
      if (guard >= 700) begin hi = -1; lo = -1; end
   endtask

   task automatic watch_low(input int n, input string tag);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1; if (cclk) seen++;
         @(negedge clk); #1; if (cclk) seen++;
      end
      chk(seen == 0, tag, seen, 0);
   endtask

   task automatic watch_pass(input int n, input string tag);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1; if (!cclk) bad++;
         @(negedge clk); #1; if (cclk) bad++;
      end
      chk(bad == 0, tag, bad, 0);
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int hi, lo;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cclk == 1'b0, "R1 cclk", cclk, 0);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(lock_err == 1'b0, "R1 lock_err", lock_err, 0);
      rd(3'd3, d); chk(d[31] == 1'b0, "R1 start", d[31], 0);
      rd(3'd0, d); chk(d[7:0] == 8'd1, "R1 divider", d[7:0], 1);

      // R2 staged writes have no effect on their own
      wr(3'd0, 32'd2); wr(3'd1, 32'd1); wr(3'd2, 32'd1);
      watch_low(20, "R2 staged only");
      chk(src_sel == 2'd0, "R2 src not applied", src_sel, 0);

      // R3 start bit timing
      wr(3'd3, 32'h8020_0000);
      rd(3'd3, d); chk(d[31] == 1'b1, "R3 start set", d[31], 1);
      chk(busy == 1'b1, "R3 busy set", busy, 1);
      @(negedge clk);
      rd(3'd3, d); chk(d[31] == 1'b0, "R3 start clear", d[31], 0);
      chk(busy == 1'b0, "R3 busy clear", busy, 0);
      chk(src_sel == 2'd1, "R3 src applied", src_sel, 1);

      // R4 R5 R6 vector walk
      for (int v = 0; v < NV; v++) begin
         int n, e;
         n = int'(VEC[v][7:0]); e = int'(VEC[v][8]);
         wr(3'd0, 32'(n)); wr(3'd1, 32'(e));
         update();
         repeat (4 * 8 + 8) @(negedge clk);
         if (e == 0) watch_low(3 * 8, "R5 disabled low");
         else if (n == 0) watch_pass(20, "R6 passthrough");
         else begin
            measure(hi, lo);
            chk(hi == n, "R4 high length", hi, n);
            chk(lo == n, "R4 low length", lo, n);
         end
      end

      // R7 wait for data path
      data_busy = 1'b1;
      wr(3'd0, 32'd3); wr(3'd1, 32'd1);
      wr(3'd3, 32'h8020_2000);
      repeat (5) @(negedge clk);
      chk(busy == 1'b1, "R7 held while busy", busy, 1);
      rd(3'd4, d); chk(d[9] == 1'b1, "R7 status busy bit", d[9], 1);
      // R8 lock error on second start
      wr(3'd3, 32'h8020_0000);
      chk(lock_err == 1'b1, "R8 lock set", lock_err, 1);
      rd(3'd3, d); chk(d[13] == 1'b1, "R8 dropped command", d[13], 1);
      wr(3'd5, 32'h0000_1000);
      chk(lock_err == 1'b0, "R8 lock cleared", lock_err, 0);
      chk(busy == 1'b1, "R7 still held", busy, 1);
      data_busy = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0, "R7 released", busy, 0);
      rd(3'd4, d); chk(d[9] == 1'b0, "R7 status idle", d[9], 0);
      repeat (20) @(negedge clk);
      measure(hi, lo);
      chk(hi == 3, "R7 applied ratio", hi, 3);

      // R9 start without update-only
      wr(3'd1, 32'd0); update();
      repeat (10) @(negedge clk);
      wr(3'd1, 32'd1); wr(3'd0, 32'd2);
      wr(3'd3, 32'h8000_0000);
      @(negedge clk);
      chk(busy == 1'b0, "R9 start cleared", busy, 0);
      watch_low(15, "R9 not applied");

      // R10 change ratio during a high pulse
      wr(3'd0, 32'd6); update();
      repeat (30) @(negedge clk);
      begin
         time t1, t2;
         int guard = 0;
         wr(3'd0, 32'd2);
         @(posedge clk); #1;
         while (cclk && guard < 200) begin @(posedge clk); #1; guard++; end
         while (!cclk && guard < 200) begin @(posedge clk); #1; guard++; end
         t1 = $time;
         wr(3'd3, 32'h8020_0000);
         @(posedge clk); #1;
         while (cclk && guard < 200) begin @(posedge clk); #1; guard++; end
         t2 = $time;
         chk(int'((t2 - t1) / PERIOD) == 6, "R10 high not cut",
             int'((t2 - t1) / PERIOD), 6);
      end
      measure(hi, lo);
      chk(hi == 2 && lo == 2, "R10 new ratio", hi, 2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule